// File: doc/BRIEF.md
# Posted-Write Buffer with Flush Triggers

This block sits between a host processor bus and the request port of a local memory controller. Host writes aimed at the local memory are posted into a small queue, so the host sees no wait state while a slot is free. Each slot holds the address, the data word and the byte enables. The queued writes go out on the memory-side request port, oldest first, one per handshake. Draining starts on one of four triggers. Once started, it runs until the queue is empty.

The triggers are a pulse on the drawing-start control input, a host idle period of a set number of cycles, the queue becoming full, and a host read request while writes are still queued. A host read is never posted. It waits until every queued write has reached memory. It is then issued on the memory port, and the returned word goes back to the host with at least one wait state. Host and memory ports run on one clock.

Top module: `wpost_buf`

## Requirements
- R1: When the host presents a write (`host_req`=1, `host_we`=1) and fewer than DEPTH entries are queued (DEPTH = BUF_BYTES / (DATA_W/8), 8 by default), the write is accepted in that cycle with `host_wait`=0. The entry stores the address, the data and the byte enables as presented.
- R2: A write presented while DEPTH entries are queued sees `host_wait`=1. It stays stalled until a cycle begins with a free slot, and it is accepted in that cycle.
- R3: Queued entries leave in arrival order. While a write drains, `mem_req`=1 and `mem_we`=1, and `mem_addr`, `mem_wdata` and `mem_be` show the oldest entry. The entry is removed in a cycle with `mem_ack`=1. Draining continues until the queue is empty, and `mem_req` is low when nothing is draining or reading.
- R4: A pulse on `render_go` in cycle t, with more than one entry queued, makes `mem_req` high in cycle t+1.
- R5: After IDLE_CYC (32) consecutive cycles without `host_req`, with entries queued, draining begins in the next cycle. The idle count restarts on every host request. The timeout fires once per idle period and does nothing when the queue is empty.
- R6: A write that brings the queue to DEPTH entries starts draining in the next cycle, even if no other trigger occurred.
- R7: A host read request while entries are queued starts draining in the next cycle. Host writes alone do not start draining.
- R8: A read keeps `host_wait`=1 until the queue is empty. It is then issued with `mem_req`=1, `mem_we`=0, `mem_addr`=`host_addr` and `mem_be` all ones. In the cycle after `mem_ack`, `host_wait`=0 for that read and `host_rdata` holds the `mem_rdata` value captured at the acknowledge.
- R9: After reset the queue is empty, `mem_req`=0, and `host_wait`=0 while no request is presented.
- R10: A read is never completed in the cycle it is first presented: `host_wait`=1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until `host_wait` is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_be | input | DATA_W/8 | Host byte enables |
| render_go | input | 1 | Drawing-start pulse; forces a drain |
| host_wait | output | 1 | Stall for the presented access |
| host_rdata | output | DATA_W | Read data, valid when a read sees `host_wait` low |
| mem_req | output | 1 | Memory-side request |
| mem_we | output | 1 | Memory-side write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory-side address |
| mem_wdata | output | DATA_W | Memory-side write data |
| mem_be | output | DATA_W/8 | Memory-side byte enables |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` on a read |

## Verification
The bench targets the idle timer's exact window. A lone posted write must go out after precisely 32 quiet cycles, and an off-by-one counter would show up as an early or late `mem_req`. Once the queue is empty, further quiet cycles must not produce a spurious request. It fills the queue with no memory acknowledges and holds a ninth write, so a design that overwrites the oldest slot or drops the stall would show a wrong drain order or an accepted write. A read issued behind queued writes checks ordering. A design that let the read overtake would put `mem_we`=0 on the port while writes remain. A read to an empty queue must still show a wait state, and its data must match what memory returned.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    // Host read sequencing
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_BUSY = 2'd1,
        RD_DONE = 2'd2
    } rd_st_e;

endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo #(
    parameter int WIDTH = 60,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_ent,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] slots [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wp = st_q.wp + PTR_W'(1);
        end
        if (pop) begin
            st_d.rp = st_q.rp + PTR_W'(1);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[st_q.wp] <= wr_ent;
        end
    end

    assign head  = slots[st_q.rp];
    assign count = st_q.cnt;

endmodule

// File: rtl/wpb_idle.sv
module wpb_idle #(
    parameter int LIMIT = 32,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic pending,
    output logic hit
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (active) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(LIMIT)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Last quiet cycle of the window, counted only once per period
    assign hit = !active && pending && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/wpost_buf.sv
module wpost_buf
    import wpb_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 32,
    parameter int BUF_BYTES = 32,
    parameter int IDLE_CYC  = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int DEPTH = BUF_BYTES / BE_W,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int ENT_W = ADDR_W + DATA_W + BE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [BE_W-1:0]   host_be,
    input  logic              render_go,
    output logic              host_wait,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    typedef struct packed {
        logic              drain;
        rd_st_e            rd;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CNT_W-1:0]  fifo_cnt;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [ENT_W-1:0]  head_ent;
    logic [ENT_W-1:0]  new_ent;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [BE_W-1:0]   head_be;
    logic full, pending, push, pop, rd_issue, idle_hit, trig;

    assign new_ent = {host_addr, host_wdata, host_be};
    assign {head_addr, head_data, head_be} = head_ent;

    assign full     = (fifo_cnt == CNT_W'(DEPTH));
    assign pending  = (fifo_cnt != '0);
    assign rd_issue = (ctl_q.rd == RD_BUSY);
    assign push     = host_req && host_we && !full;
    assign mem_req  = rd_issue || (ctl_q.drain && pending);
    assign pop      = mem_req && mem_ack && !rd_issue;
    assign cnt_nxt  = fifo_cnt + CNT_W'(push) - CNT_W'(pop);

    wpb_fifo #(
        .WIDTH(ENT_W),
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wr_ent(new_ent),
        .pop   (pop),
        .head  (head_ent),
        .count (fifo_cnt)
    );

    wpb_idle #(
        .LIMIT(IDLE_CYC)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (host_req),
        .pending(pending),
        .hit    (idle_hit)
    );

    // Any of the four flush causes
    assign trig = render_go
               || idle_hit
               || (host_req && !host_we && pending)
               || (cnt_nxt == CNT_W'(DEPTH));

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.drain = (ctl_q.drain || trig) && (cnt_nxt != '0);
        unique case (ctl_q.rd)
            RD_IDLE: begin
                if (host_req && !host_we && !pending) begin
                    ctl_d.rd = RD_BUSY;
                end
            end
            RD_BUSY: begin
                if (mem_ack) begin
                    ctl_d.rd    = RD_DONE;
                    ctl_d.rdata = mem_rdata;
                end
            end
            RD_DONE: begin
                ctl_d.rd = RD_IDLE;
            end
            default: begin
                ctl_d.rd = RD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{drain: 1'b0, rd: RD_IDLE, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (!host_req) begin
            host_wait = 1'b0;
        end else if (host_we) begin
            host_wait = full;
        end else begin
            host_wait = (ctl_q.rd != RD_DONE);
        end
    end

    assign host_rdata = ctl_q.rdata;
    assign mem_we     = !rd_issue;
    assign mem_addr   = rd_issue ? host_addr : head_addr;
    assign mem_wdata  = head_data;
    assign mem_be     = rd_issue ? {BE_W{1'b1}} : head_be;

endmodule

// File: rtl/wpb_chk.sv
module wpb_chk #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic              host_wait,
    input logic              render_go,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  cnt,
    input logic              pop
);

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    read_behind_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> cnt == '0);

    // R10
    read_first_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_req) && !host_we |-> host_wait);

    // R4
    render_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        render_go && cnt > CNT_W'(1) |=> mem_req);

    // R1
    write_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_we && !host_wait
        |=> cnt == $past(cnt) + CNT_W'(1) - CNT_W'($past(pop)));

endmodule

bind wpost_buf wpb_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_req (host_req),
    .host_we  (host_we),
    .host_wait(host_wait),
    .render_go(render_go),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .cnt      (fifo_cnt),
    .pop      (pop)
);

// File: tb/sim_wpost_buf.sv
module sim_wpost_buf;

    localparam int TCLK  = 10;
    localparam int AW    = 24;
    localparam int DW    = 32;
    localparam int BW    = 4;
    localparam int DEPTH = 8;
    localparam int IDLE  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0, render_go = 1'b0, mem_ack = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [BW-1:0] host_be = '0;
    logic          host_wait, mem_req, mem_we;
    logic [DW-1:0] host_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be;

    always #(TCLK/2) clk = ~clk;

    assign mem_rdata = {8'hA5, mem_addr};

    wpost_buf u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .render_go(render_go), .host_wait(host_wait), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0, cyc_n = 0, ack_mode = 0;
    bit finished = 0;

    // Reference model state
    logic [AW-1:0] qa[$];
    logic [DW-1:0] qd[$];
    logic [BW-1:0] qb[$];
    bit            m_drain = 0;
    int            m_idle = 0;
    int            m_rd = 0;
    logic [DW-1:0] m_rdata = '0;

    bit            obs_mreq, obs_wait;
    logic [DW-1:0] obs_rdata;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc_n);
        end
    endtask

    // One clock: compare against the model, then advance it
    task automatic cyc();
        int  sz, nsz;
        bit  full, wt, mreq, push, pop, hit, trig;
        mem_ack = (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? (cyc_n % 3 != 0) : 1'b0;
        #1;
        sz   = qa.size();
        full = (sz == DEPTH);
        wt   = host_req && (host_we ? full : (m_rd != 2));
        mreq = (m_rd == 1) || (m_drain && sz > 0);
        chk(host_wait === wt, "R2 host_wait", 64'(host_wait), 64'(wt));
        chk(mem_req === mreq, "R3 mem_req", 64'(mem_req), 64'(mreq));
        if (mreq && m_rd == 1) begin
            chk(mem_we === 1'b0, "R8 read mem_we", 64'(mem_we), 64'd0);
            chk(mem_addr === host_addr, "R8 read addr", 64'(mem_addr), 64'(host_addr));
            chk(mem_be === 4'hF, "R8 read be", 64'(mem_be), 64'hF);
        end else if (mreq) begin
            chk(mem_we === 1'b1, "R3 mem_we", 64'(mem_we), 64'd1);
            chk(mem_addr === qa[0], "R3 mem_addr", 64'(mem_addr), 64'(qa[0]));
            chk(mem_wdata === qd[0], "R3 mem_wdata", 64'(mem_wdata), 64'(qd[0]));
            chk(mem_be === qb[0], "R1 mem_be", 64'(mem_be), 64'(qb[0]));
        end
        if (m_rd == 2) begin
            chk(host_rdata === m_rdata, "R8 host_rdata", 64'(host_rdata), 64'(m_rdata));
        end
        obs_mreq  = mem_req;
        obs_wait  = host_wait;
        obs_rdata = host_rdata;

        push = host_req && host_we && !full;
        pop  = mreq && mem_ack && (m_rd != 1);
        if (pop) begin
            void'(qa.pop_front()); void'(qd.pop_front()); void'(qb.pop_front());
        end
        if (push) begin
            qa.push_back(host_addr); qd.push_back(host_wdata); qb.push_back(host_be);
        end
        nsz  = qa.size();
        hit  = !host_req && (m_idle == IDLE - 1) && (sz > 0);
        trig = render_go || hit || (host_req && !host_we && sz > 0) || (nsz == DEPTH);
        m_drain = (m_drain || trig) && (nsz > 0);
        m_idle  = host_req ? 0 : ((m_idle == IDLE) ? IDLE : m_idle + 1);
        case (m_rd)
            0: if (host_req && !host_we && sz == 0) m_rd = 1;
            1: if (mem_ack) begin m_rd = 2; m_rdata = {8'hA5, host_addr}; end
            default: m_rd = 0;
        endcase
        @(posedge clk);
        @(negedge clk);
        cyc_n++;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [BW-1:0] b, output int n);
        bit acc;
        host_req = 1; host_we = 1; host_addr = a; host_wdata = d; host_be = b;
        n = 0;
        do begin
            acc = (qa.size() < DEPTH);
            cyc();
            n++;
        end while (!acc && n < 300);
        host_req = 0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output int waits, output logic [DW-1:0] rd);
        bit done = 0;
        host_req = 1; host_we = 0; host_addr = a;
        waits = 0; rd = '0;
        while (!done && waits < 300) begin
            done = (m_rd == 2);
            cyc();
            if (done) rd = obs_rdata;
            else waits++;
        end
        host_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, k, w;
        bit any;
        logic [DW-1:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R9: reset state
        cyc();
        chk(obs_wait == 0, "R9 wait after reset", 64'(obs_wait), 0);
        chk(obs_mreq == 0, "R9 mem_req after reset", 64'(obs_mreq), 0);

        // R1 / R5: lone write, then the idle window
        ack_mode = 0;
        do_write(24'h000100, 32'h1111_0001, 4'hF, n);
        chk(n == 1, "R1 zero-wait write", 64'(n), 1);
        k = 0;
        while (!obs_mreq && k < 80) begin cyc(); if (!obs_mreq) k++; end
        chk(k == IDLE, "R5 idle cycles before flush", 64'(k), 64'(IDLE));
        idle(2);
        any = 0;
        for (int i = 0; i < 45; i++) begin cyc(); any |= obs_mreq; end
        chk(any == 0, "R5 no retrigger when empty", 64'(any), 0);

        // R4: drawing-start pulse
        do_write(24'h000200, 32'h2222_0001, 4'h5, n);
        do_write(24'h000201, 32'h2222_0002, 4'hA, n);
        idle(2);
        chk(obs_mreq == 0, "R7 writes alone do not drain", 64'(obs_mreq), 0);
        render_go = 1; cyc(); render_go = 0;
        cyc();
        chk(obs_mreq == 1, "R4 drain after render_go", 64'(obs_mreq), 1);
        idle(4);

        // R7 / R8: read behind queued writes, stuttering memory
        ack_mode = 1;
        do_write(24'h000300, 32'h3333_0001, 4'h3, n);
        do_write(24'h000301, 32'h3333_0002, 4'hC, n);
        do_write(24'h000302, 32'h3333_0003, 4'h1, n);
        do_read(24'h000300, w, rd);
        chk(w >= 4, "R8 read waits behind writes", 64'(w), 4);
        chk(rd == {8'hA5, 24'h000300}, "R8 read data", 64'(rd), 64'({8'hA5, 24'h000300}));
        idle(3);

        // R10: read on empty queue
        ack_mode = 0;
        do_read(24'h0ABCDE, w, rd);
        chk(w >= 1, "R10 read has a wait", 64'(w), 1);
        chk(rd == {8'hA5, 24'h0ABCDE}, "R8 empty read data", 64'(rd), 64'({8'hA5, 24'h0ABCDE}));
        idle(2);

        // R6: filling the queue starts a drain
        for (int i = 0; i < DEPTH - 1; i++)
            do_write(24'h000400 + 24'(i), 32'h4444_0000 + 32'(i), 4'(i + 1), n);
        chk(obs_mreq == 0, "R6 no drain below full", 64'(obs_mreq), 0);
        do_write(24'h000407, 32'h4444_0007, 4'h8, n);
        cyc();
        chk(obs_mreq == 1, "R6 drain when full", 64'(obs_mreq), 1);
        idle(DEPTH + 2);

        // R2: stall on full queue with no acknowledge
        ack_mode = 2;
        for (int i = 0; i < DEPTH; i++)
            do_write(24'h000500 + 24'(i), 32'h5555_0000 + 32'(i), 4'hF, n);
        host_req = 1; host_we = 1; host_addr = 24'h000508;
        host_wdata = 32'h5555_0008; host_be = 4'h6;
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk(obs_wait == 1, "R2 stall while full", 64'(obs_wait), 1);
        end
        host_req = 0;
        ack_mode = 1;
        do_write(24'h000508, 32'h5555_0008, 4'h6, n);
        chk(n >= 1, "R2 stalled write accepted", 64'(n), 1);
        idle(IDLE + 20);
        chk(qa.size() == 0 && obs_mreq == 0, "R3 queue drained", 64'(obs_mreq), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule